// File: doc/BRIEF.md
# Oversampled Wire Hit Detector

The block watches a bank of wires whose signals arrive already deserialized: on every clock each wire delivers a parallel slice of consecutive samples, the lowest bit being the earliest. During an event window, opened by a start pulse and closed by a stop pulse, every wire runs its own pulse finder. A pulse counts as a hit when the wire stays high for at least four samples and then stays low for at least four samples. The time of the hit is the index of its first high sample, counted from the window start. It is stored as a 16-bit word.

Each wire keeps up to four hit times and a 4-bit hit count. After the window closes, two word-addressed read ports deliver the results as 32-bit words. The count port gives one header word and then the packed per-wire counts. The data port gives the hit times, two to a word. The run counters of each wire carry over from one slice to the next, so a pulse that straddles a slice boundary is found like any other.

Top module: `wire_hit_detector`

## Requirements
- R1: A hit is recorded only for a run of at least 4 consecutive high samples that is followed by at least 4 consecutive low samples, with all of those samples inside the window. A low gap shorter than 4 discards the high run before it.
- R2: No more than 4 hits are kept per wire. Hits found after the fourth leave both the stored times and the count unchanged, and the count never exceeds 4.
- R3: The stored time of a hit is k*8+b for its first high sample, where k is the slice number within the window (first slice 0) and b is the bit within the slice (bit 0 earliest). A run that crosses a slice boundary is measured as one run.
- R4: Count port addresses 1 to 6 return packed counts. Wire w sits in word 1+w/8, in bits [4*(w%8)+3 : 4*(w%8)].
- R5: Count port address 0 returns the header: bits [31:8] hold the number of windows opened since reset and bits [7:0] hold dev_id.
- R6: Data port address 2*w+j holds hit 2*j of wire w in bits [15:0] and hit 2*j+1 in bits [31:16]. Slots without a hit read 0. Data addresses 96 and above, and count address 7, read 0.
- R7: A start pulse clears all counts and times and opens the window. Slices are taken on each following cycle up to and including the cycle in which stop is high. Samples outside the window have no effect. When start and stop are high together, start wins.
- R8: After reset the window is closed, all counts and times are 0, and the header holds a window number of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_start | input | 1 | Opens a new event window and clears the results |
| win_stop | input | 1 | Marks the last slice of the window |
| dev_id | input | 8 | Identifier placed in the header |
| samples | input | 384 | Slice of 8 samples per wire; wire w uses bits [8w+7:8w] |
| cnt_addr | input | 3 | Count port word address |
| cnt_word | output | 32 | Count port read data |
| dat_addr | input | 7 | Data port word address |
| dat_word | output | 32 | Data port read data |
| win_open | output | 1 | High while the window is taking slices |

## Verification
Two events can meet in one cycle: the closing of a pulse's fourth low sample and the closing of the window. A pulse can also complete in the same slice as the stop pulse or in the slice just after it. The bench places pulses whose fourth low sample falls in the stop slice, and pulses that come one sample short, and then checks that only the first kind appear in the counts and times. A second case raises start and stop together and checks that the window still opens and that the hits in its slices are recorded.

// File: rtl/whd_pkg.sv
package whd_pkg;
  localparam int CNT_W  = 4;
  localparam int WORD_W = 32;
  localparam int EVT_W  = 24;

  function automatic logic [WORD_W-1:0] hdr_word(input logic [EVT_W-1:0] evt,
                                                 input logic [7:0] id);
    return {evt, id};
  endfunction

  function automatic int sample_time(input int slice_idx, input int bit_idx,
                                     input int slice_w);
    return slice_idx * slice_w + bit_idx;
  endfunction
endpackage

// File: rtl/whd_lane.sv
module whd_lane #(
  parameter int SLICE   = 8,
  parameter int TW      = 16,
  parameter int HMAX    = 4,
  parameter int RUN_MIN = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               en,
  input  logic [SLICE-1:0]   bits,
  input  logic [TW-1:0]      base,
  output logic [3:0]         count,
  output logic [HMAX*TW-1:0] times,
  output logic               took
);
  localparam int RW = $clog2(RUN_MIN + 1);
  localparam int NW = $clog2(HMAX + 1);
  localparam logic [RW-1:0] RMAX = RW'(RUN_MIN);
  localparam logic [NW-1:0] NMAX = NW'(HMAX);

  logic [RW-1:0] hi_q, lo_q, hi_d, lo_d;
  logic          arm_q, arm_d;
  logic [TW-1:0] st_q, st_d, cand_q, cand_d;
  logic [NW-1:0] n_q, n_d;
  logic [TW-1:0] tm_q [HMAX];
  logic [TW-1:0] tm_d [HMAX];
  logic          tk;

  always_comb begin
    hi_d = hi_q; lo_d = lo_q; arm_d = arm_q;
    st_d = st_q; cand_d = cand_q; n_d = n_q; tk = 1'b0;
    for (int h = 0; h < HMAX; h++) tm_d[h] = tm_q[h];
    for (int b = 0; b < SLICE; b++) begin
      if (bits[b]) begin
        if (lo_d != '0) begin
          arm_d = 1'b0;
          lo_d  = '0;
        end
        if (hi_d == '0) st_d = base + TW'(b);
        if (hi_d != RMAX) begin
          hi_d = hi_d + RW'(1);
          if (hi_d == RMAX) begin
            arm_d  = 1'b1;
            cand_d = st_d;
          end
        end
      end else begin
        hi_d = '0;
        if (arm_d) begin
          lo_d = lo_d + RW'(1);
          if (lo_d == RMAX) begin
            arm_d = 1'b0;
            lo_d  = '0;
            if (n_d != NMAX) begin
              tm_d[n_d] = cand_d;
              n_d = n_d + NW'(1);
              tk  = 1'b1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      hi_q <= '0; lo_q <= '0; arm_q <= 1'b0;
      st_q <= '0; cand_q <= '0; n_q <= '0;
      for (int h = 0; h < HMAX; h++) tm_q[h] <= '0;
    end else if (en) begin
      hi_q <= hi_d; lo_q <= lo_d; arm_q <= arm_d;
      st_q <= st_d; cand_q <= cand_d; n_q <= n_d;
      for (int h = 0; h < HMAX; h++) tm_q[h] <= tm_d[h];
    end
  end

  assign count = 4'(n_q);
  assign took  = en && !clr && tk;

  generate
    for (genvar h = 0; h < HMAX; h++) begin : g_pack
      assign times[h*TW +: TW] = tm_q[h];
    end
  endgenerate
endmodule

// File: rtl/whd_readout.sv
module whd_readout
  import whd_pkg::*;
#(
  parameter int NWIRE = 48,
  parameter int TW    = 16,
  parameter int HMAX  = 4,
  parameter int CA_W  = 3,
  parameter int DA_W  = 7
) (
  input  logic [NWIRE*CNT_W-1:0]   cnt_flat,
  input  logic [NWIRE*HMAX*TW-1:0] time_flat,
  input  logic [EVT_W-1:0]         evt,
  input  logic [7:0]               dev_id,
  input  logic [CA_W-1:0]          cnt_addr,
  input  logic [DA_W-1:0]          dat_addr,
  output logic [WORD_W-1:0]        cnt_word,
  output logic [WORD_W-1:0]        dat_word
);
  localparam int NCW  = NWIRE * CNT_W / WORD_W;
  localparam int NDAT = NWIRE * HMAX * TW / WORD_W;

  always_comb begin
    int ca;
    ca = int'(cnt_addr);
    if (ca == 0)
      cnt_word = hdr_word(evt, dev_id);
    else if (ca <= NCW)
      cnt_word = cnt_flat[(ca-1)*WORD_W +: WORD_W];
    else
      cnt_word = '0;
  end

  always_comb begin
    int da;
    da = int'(dat_addr);
    if (da < NDAT)
      dat_word = time_flat[da*WORD_W +: WORD_W];
    else
      dat_word = '0;
  end
endmodule

// File: rtl/wire_hit_detector.sv
module wire_hit_detector
  import whd_pkg::*;
#(
  parameter int NWIRE   = 48,
  parameter int SLICE   = 8,
  parameter int TW      = 16,
  parameter int HMAX    = 4,
  parameter int RUN_MIN = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   win_start,
  input  logic                   win_stop,
  input  logic [7:0]             dev_id,
  input  logic [NWIRE*SLICE-1:0] samples,
  input  logic [2:0]             cnt_addr,
  output logic [WORD_W-1:0]      cnt_word,
  input  logic [6:0]             dat_addr,
  output logic [WORD_W-1:0]      dat_word,
  output logic                   win_open
);
  logic                     open_q;
  logic [EVT_W-1:0]         evt_q;
  logic [TW-1:0]            base_q;
  logic [NWIRE*CNT_W-1:0]   cnt_flat;
  logic [NWIRE*HMAX*TW-1:0] time_flat;
  logic [NWIRE-1:0]         took_flat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      evt_q  <= '0;
      base_q <= '0;
    end else if (win_start) begin
      open_q <= 1'b1;
      evt_q  <= evt_q + EVT_W'(1);
      base_q <= '0;
    end else begin
      if (win_stop) open_q <= 1'b0;
      if (open_q) base_q <= base_q + TW'(SLICE);
    end
  end

  generate
    for (genvar w = 0; w < NWIRE; w++) begin : g_lane
      whd_lane #(.SLICE(SLICE), .TW(TW), .HMAX(HMAX), .RUN_MIN(RUN_MIN)) u_lane (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (win_start),
        .en    (open_q),
        .bits  (samples[w*SLICE +: SLICE]),
        .base  (base_q),
        .count (cnt_flat[w*CNT_W +: CNT_W]),
        .times (time_flat[w*HMAX*TW +: HMAX*TW]),
        .took  (took_flat[w])
      );
    end
  endgenerate

  whd_readout #(.NWIRE(NWIRE), .TW(TW), .HMAX(HMAX), .CA_W(3), .DA_W(7)) u_rd (
    .cnt_flat  (cnt_flat),
    .time_flat (time_flat),
    .evt       (evt_q),
    .dev_id    (dev_id),
    .cnt_addr  (cnt_addr),
    .dat_addr  (dat_addr),
    .cnt_word  (cnt_word),
    .dat_word  (dat_word)
  );

  assign win_open = open_q;
endmodule

// File: rtl/whd_checks.sv
module whd_checks #(
  parameter int NWIRE = 48
) (
  input logic               clk,
  input logic               rst_n,
  input logic               win_start,
  input logic               open_q,
  input logic [23:0]        evt_q,
  input logic [NWIRE*4-1:0] cnt_flat,
  input logic [NWIRE-1:0]   took_flat
);
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    win_start |=> (cnt_flat == '0)); // R7

  AST_CLOSED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_q && !win_start) |=> $stable(cnt_flat)); // R7

  AST_EVT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    win_start |=> (evt_q == $past(evt_q) + 24'd1)); // R5

  generate
    for (genvar w = 0; w < NWIRE; w++) begin : g_wire
      AST_CNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_flat[w*4 +: 4] <= 4'd4); // R2

      AST_TOOK_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        took_flat[w] |=> (cnt_flat[w*4 +: 4] == $past(cnt_flat[w*4 +: 4]) + 4'd1)); // R2

      AST_NO_SILENT_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (!took_flat[w] && !win_start) |=> $stable(cnt_flat[w*4 +: 4])); // R1
    end
  endgenerate
endmodule

bind wire_hit_detector whd_checks #(.NWIRE(NWIRE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .win_start (win_start),
  .open_q    (open_q),
  .evt_q     (evt_q),
  .cnt_flat  (cnt_flat),
  .took_flat (took_flat)
);

// File: tb/sim_wire_hit_detector.sv
`timescale 1ns/1ps
module sim_wire_hit_detector;
  localparam int NW = 48;
  localparam int SL = 8;
  localparam int MAXS = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic win_start = 1'b0, win_stop = 1'b0;
  logic [7:0] dev_id = 8'hA5;
  logic [NW*SL-1:0] samples = '0;
  logic [2:0] cnt_addr = '0;
  logic [6:0] dat_addr = '0;
  logic [31:0] cnt_word, dat_word;
  logic win_open;

  int total = 0, bad = 0;
  int exp_evt = 0;
  bit strm [NW][MAXS];
  int exp_n [NW];
  int exp_t [NW][4];

  always #2.5 clk = ~clk;

  wire_hit_detector u0 (
    .clk(clk), .rst_n(rst_n), .win_start(win_start), .win_stop(win_stop),
    .dev_id(dev_id), .samples(samples), .cnt_addr(cnt_addr), .cnt_word(cnt_word),
    .dat_addr(dat_addr), .dat_word(dat_word), .win_open(win_open)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_strm();
    for (int w = 0; w < NW; w++)
      for (int i = 0; i < MAXS; i++) strm[w][i] = 1'b0;
  endtask

  task automatic set_ones(input int w, input int from, input int len);
    for (int i = from; i < from + len && i < MAXS; i++) strm[w][i] = 1'b1;
  endtask

  // expected hits: scan each high run, measure it and the low gap after it
  task automatic model(input int nsmp);
    for (int w = 0; w < NW; w++) begin
      int i, j, z;
      exp_n[w] = 0;
      for (int h = 0; h < 4; h++) exp_t[w][h] = 0;
      i = 0;
      while (i < nsmp) begin
        if (strm[w][i]) begin
          j = i;
          while (j < nsmp && strm[w][j]) j++;
          z = j;
          while (z < nsmp && !strm[w][z]) z++;
          if ((j - i) >= 4 && (z - j) >= 4 && exp_n[w] < 4) begin
            exp_t[w][exp_n[w]] = i;
            exp_n[w]++;
          end
          i = j;
        end else i++;
      end
    end
  endtask

  task automatic read_all(input string tag);
    logic [31:0] e;
    for (int a = 0; a < 8; a++) begin
      cnt_addr = 3'(a);
      #1;
      if (a == 0) chk({tag, " R5 header"}, cnt_word, {24'(exp_evt), dev_id});
      else if (a == 7) chk({tag, " R6 count addr 7"}, cnt_word, 32'h0);
      else begin
        e = '0;
        for (int k = 0; k < 8; k++) e[4*k +: 4] = 4'(exp_n[(a-1)*8 + k]);
        chk({tag, " R4 counts"}, cnt_word, e);
      end
    end
    for (int a = 0; a < 98; a++) begin
      dat_addr = 7'(a);
      #1;
      e = '0;
      if (a < 96) begin
        int w, h0;
        w = a / 2; h0 = (a % 2) * 2;
        if (exp_n[w] > h0)     e[15:0]  = 16'(exp_t[w][h0]);
        if (exp_n[w] > h0 + 1) e[31:16] = 16'(exp_t[w][h0+1]);
        chk({tag, " R3 hit times"}, dat_word, e);
      end else chk({tag, " R6 data addr out of range"}, dat_word, 32'h0);
    end
  endtask

  task automatic run_window(input int nsl, input bit both, input string tag);
    @(negedge clk);
    win_start = 1'b1; win_stop = both; samples = '0;
    @(negedge clk);
    win_start = 1'b0; win_stop = 1'b0;
    exp_evt++;
    chk({tag, " R7 window open"}, 32'(win_open), 32'd1);
    for (int k = 0; k < nsl; k++) begin
      for (int w = 0; w < NW; w++)
        for (int b = 0; b < SL; b++) samples[w*SL + b] = strm[w][k*SL + b];
      win_stop = (k == nsl - 1);
      @(negedge clk);
    end
    win_stop = 1'b0;
    // pulses after the window must be ignored
    for (int c = 0; c < 3; c++) begin
      for (int w = 0; w < NW; w++) samples[w*SL +: SL] = (c == 1) ? 8'h00 : 8'h0F;
      @(negedge clk);
    end
    samples = '0;
    chk({tag, " R7 window closed"}, 32'(win_open), 32'd0);
    model(nsl * SL);
    read_all(tag);
  endtask

  task automatic t_reset();
    for (int w = 0; w < NW; w++) exp_n[w] = 0;
    chk("R8 window closed after reset", 32'(win_open), 32'd0);
    read_all("R8 reset");
  endtask

  task automatic t_basic();
    clear_strm();
    for (int w = 0; w < NW; w++) begin
      int o;
      o = (w * 3) % 20;
      case (w % 4)
        0: set_ones(w, o, 4);
        1: set_ones(w, o, 3);
        2: begin set_ones(w, o, 4); set_ones(w, o + 7, 5); end
        default: set_ones(w, o, 10);
      endcase
    end
    run_window(8, 1'b0, "R1 basic");
  endtask

  task automatic t_overflow();
    clear_strm();
    for (int w = 0; w < NW; w++)
      for (int p = 0; p < 7; p++) set_ones(w, (w % 8) + p * 8, 4);
    run_window(8, 1'b0, "R2 overflow");
  endtask

  task automatic t_edge();
    clear_strm();
    for (int w = 0; w < NW; w++)
      if (w % 2 == 0) set_ones(w, 24, 4); else set_ones(w, 25, 4);
    run_window(4, 1'b0, "R7 stop edge");
  endtask

  task automatic t_startstop();
    clear_strm();
    for (int w = 0; w < NW; w++) set_ones(w, 6 + (w % 5), 6);
    run_window(3, 1'b1, "R7 start wins");
  endtask

  task automatic t_random(input int nsl);
    clear_strm();
    for (int w = 0; w < NW; w++) begin
      int p; bit v;
      p = 0; v = bit'($urandom_range(1, 0));
      while (p < nsl * SL) begin
        int len;
        len = $urandom_range(9, 1);
        if (v) set_ones(w, p, len);
        p += len; v = !v;
      end
    end
    run_window(nsl, 1'b0, "R3 random");
  endtask

  task automatic t_empty();
    clear_strm();
    run_window(2, 1'b0, "R7 restart clears");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R7 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_overflow();
    t_edge();
    t_startstop();
    for (int r = 0; r < 3; r++) t_random(16);
    t_empty();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule